// File: doc/BRIEF.md
# Flash Controller Command Sequencer

This block is the register front end and operation sequencer of an embedded flash memory controller. Software talks to it through a small 32-bit register window (key, status and control words) and hands it program data through a separate flash-window write channel that carries a byte offset, an access size and up to 64 bits of data. Control writes stay blocked until a two-word key is presented. After that, the control word selects sector erase, mass erase or programming, and the access width that programming expects. A busy flag covers every operation. Sequence, width, alignment, write-protect and operation faults each latch a sticky status bit.

The flash cells are modelled by an internal byte array. Its twelve sectors have mixed sizes and are scaled by a parameter. Erase and program latencies are parameters as well. Erase fills a sector with 0xFF. Programming can only clear bits. A byte read port exposes the array contents.

The data channel uses valid/ready. `fw_ready` is low while an operation is busy and in any cycle that carries a control-register write. A beat transfers on a cycle where `fw_valid` and `fw_ready` are both high, and the source must hold its fields stable until then. The register port has no back-pressure: a write takes effect on the clock edge where `reg_valid` and `reg_write` are high. Read data is combinational from `reg_addr`.

Top module: `flc_cmd_if`

## Requirements
- R1: After reset the status word reads 0 and the control word reads 0x8000_0000 (lock bit 31 set). `busy` is low, `fw_ready` is high and every array byte reads 0xFF.
- R2: Writing 0x45670123 and then 0xCDEF89AB to the key register (offset 0x04) unlocks the controller, and control bit 31 then reads 0. A further key write while unlocked leaves it unlocked.
- R3: A wrong value at either key step keeps the controller locked until reset, even if the correct pair follows. A control write (offset 0x10) while locked changes nothing and sets sequence-error status bit 7.
- R4: An unlocked control write with bit 31 set locks the controller again. A fresh correct key pair unlocks it.
- R5: An unlocked control write with erase-sector bit 1, a sector number in bits 6:3 and start bit 16 raises `busy` (status bit 16) for ERASE_CYCLES cycles and then sets every byte of that sector to 0xFF. The sectors, laid out from offset 0 in units of UNIT bytes, are 0–3 of 1 unit each, sector 4 of 4 units, and 5–11 of 8 units each.
- R6: Mass-erase bit 2 together with start bit 16 erases all sectors after ERASE_CYCLES busy cycles. Setting bit 1 and bit 2 together with start sets status bit 7 and does nothing else.
- R7: With program bit 0 set and program size in control bits 9:8 (0=1, 1=2, 2=4, 3=8 bytes), a data beat whose `fw_size` uses the same code raises `busy` for PROG_CYCLES cycles. The addressed bytes then become old AND new, with byte k taken from `fw_data[8k+7:8k]`. Array contents change only at the end of an operation.
- R8: A beat whose size code differs from bits 9:8 sets width-error bit 6. A beat whose offset is not a multiple of its byte count sets alignment-error bit 5. Only one error is flagged per beat, with priority sequence > width > alignment > protect. An errored beat leaves the array untouched and never raises `busy`.
- R9: An erase or program aimed at a sector whose `wp_mask` bit is set sets protect-error bit 4 and has no effect. A mass erase with any `wp_mask` bit set does the same.
- R10: A sector erase with a sector number above 11 sets operation-error bit 1. A data beat while locked or with bit 0 clear sets bit 7. Neither starts an operation.
- R11: Control writes during `busy` are ignored, so the control word reads the same afterwards. `fw_ready` is low during `busy`.
- R12: Writing the status register (offset 0x0C) clears each error bit written as 1 and leaves the bits written as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | Access is a write |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| fw_valid | input | 1 | Flash-window data beat valid |
| fw_ready | output | 1 | Flash-window beat accepted |
| fw_addr | input | AW | Byte offset of the beat in the array |
| fw_size | input | 2 | Beat size code (bytes = 2^code) |
| fw_data | input | 64 | Beat data, byte 0 in bits 7:0 |
| wp_mask | input | 12 | Per-sector write-protect |
| rd_addr | input | AW | Array byte read address |
| rd_data | output | 8 | Array byte at rd_addr |
| busy | output | 1 | Operation in progress |

## Verification
Status flags and control fields update on the clock edge that takes a register write or data beat. The bench therefore reads them back at the falling edge after that write. `busy` is high from the falling edge after the accepting clock for exactly PROG_CYCLES or ERASE_CYCLES falling edges, and the bench counts those edges to check each latency. Array bytes change on the same edge where `busy` drops, so the bench compares them against its own shadow array only after the first falling edge with `busy` low. An error case must show a busy count of zero.

// File: rtl/flc_pkg.sv
package flc_pkg;

  localparam int NUM_SECT = 12;

  localparam logic [31:0] KEY_FIRST  = 32'h4567_0123;
  localparam logic [31:0] KEY_SECOND = 32'hCDEF_89AB;

  localparam logic [4:0] OFF_ACCESS  = 5'h00;
  localparam logic [4:0] OFF_KEY     = 5'h04;
  localparam logic [4:0] OFF_OPTKEY  = 5'h08;
  localparam logic [4:0] OFF_STAT    = 5'h0C;
  localparam logic [4:0] OFF_CTRL    = 5'h10;
  localparam logic [4:0] OFF_OPTCTRL = 5'h14;

  localparam int CB_PG     = 0;
  localparam int CB_SER    = 1;
  localparam int CB_MER    = 2;
  localparam int CB_SNB_LO = 3;
  localparam int CB_PSZ_LO = 8;
  localparam int CB_STRT   = 16;
  localparam int CB_LOCK   = 31;

  // internal sticky error vector positions
  localparam int E_SEQ = 4;
  localparam int E_PAR = 3;
  localparam int E_ALN = 2;
  localparam int E_WRP = 1;
  localparam int E_OPE = 0;

  typedef enum logic [1:0] {KS_IDLE, KS_HALF, KS_OPEN, KS_DEAD} key_st_e;
  typedef enum logic [1:0] {OP_NONE, OP_SECT, OP_MASS, OP_PROG} op_e;

  // sector index of a byte offset, sizes 1,1,1,1,4,8x7 units
  function automatic int sect_of(input int a, input int unit);
    int u;
    u = a / unit;
    if (u < 4) return u;
    if (u < 8) return 4;
    return 5 + (u - 8) / 8;
  endfunction

endpackage

// File: rtl/flc_keylock.sv
module flc_keylock
  import flc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_we,
  input  logic [31:0] key_val,
  input  logic        relock,
  output logic        unlocked
);

  key_st_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= KS_IDLE;
    end else begin
      unique case (st_q)
        KS_IDLE: if (key_we) st_q <= (key_val == KEY_FIRST) ? KS_HALF : KS_DEAD;
        KS_HALF: if (key_we) st_q <= (key_val == KEY_SECOND) ? KS_OPEN : KS_DEAD;
        KS_OPEN: if (relock) st_q <= KS_IDLE;
        default: st_q <= KS_DEAD;
      endcase
    end
  end

  assign unlocked = (st_q == KS_OPEN);

endmodule

// File: rtl/flc_sector_map.sv
module flc_sector_map
  import flc_pkg::*;
#(
  parameter int UNIT = 16,
  parameter int AW   = 10
) (
  input  logic [AW-1:0] addr,
  output logic [3:0]    sect
);

  always_comb begin
    sect = 4'(sect_of(int'(addr), UNIT));
  end

endmodule

// File: rtl/flc_array.sv
module flc_array
  import flc_pkg::*;
#(
  parameter int UNIT = 16,
  parameter int AW   = 10,
  localparam int BYTES = 64 * UNIT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          erase_go,
  input  logic          erase_all,
  input  logic [3:0]    erase_sect,
  input  logic          prog_go,
  input  logic [AW-1:0] prog_addr,
  input  logic [1:0]    prog_size,
  input  logic [63:0]   prog_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  logic [7:0] cells [BYTES];
  logic [2:0] lane_mask;

  assign lane_mask = 3'((4'd1 << prog_size) - 4'd1);

  for (genvar i = 0; i < BYTES; i++) begin : g_cell
    localparam logic [3:0]    HOME = 4'(sect_of(i, UNIT));
    localparam logic [AW-1:0] IDX  = AW'(i);
    logic [7:0] q;
    logic       hit;
    logic [2:0] lane;

    assign hit  = ((IDX ^ prog_addr) >> prog_size) == '0;
    assign lane = IDX[2:0] & lane_mask;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= 8'hFF;
      end else if (erase_go && (erase_all || erase_sect == HOME)) begin
        q <= 8'hFF;
      end else if (prog_go && hit) begin
        q <= q & prog_data[{lane, 3'b000} +: 8];
      end
    end

    assign cells[i] = q;
  end

  assign rd_data = cells[rd_addr];

endmodule

// File: rtl/flc_cmd_if.sv
module flc_cmd_if
  import flc_pkg::*;
#(
  parameter int UNIT         = 16,
  parameter int ERASE_CYCLES = 20,
  parameter int PROG_CYCLES  = 4,
  localparam int BYTES   = 64 * UNIT,
  localparam int AW      = $clog2(BYTES),
  localparam int LAT_MAX = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES,
  localparam int CNT_W   = $clog2(LAT_MAX + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_valid,
  input  logic           reg_write,
  input  logic [4:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic           fw_valid,
  output logic           fw_ready,
  input  logic [AW-1:0]  fw_addr,
  input  logic [1:0]     fw_size,
  input  logic [63:0]    fw_data,
  input  logic [11:0]    wp_mask,
  input  logic [AW-1:0]  rd_addr,
  output logic [7:0]     rd_data,
  output logic           busy
);

  logic wr_any, wr_key, wr_ctrl, wr_stat;
  assign wr_any  = reg_valid && reg_write;
  assign wr_key  = wr_any && (reg_addr == OFF_KEY);
  assign wr_ctrl = wr_any && (reg_addr == OFF_CTRL);
  assign wr_stat = wr_any && (reg_addr == OFF_STAT);

  logic             unlocked;
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  op_e              op_q;
  logic [3:0]       sect_q;
  logic [AW-1:0]    paddr_q;
  logic [1:0]       psz_op_q;
  logic [63:0]      pdata_q;

  logic       pg_q, ser_q, mer_q;
  logic [3:0] snb_q;
  logic [1:0] psz_q;
  logic [4:0] err_q, err_set, err_clr;

  logic ctrl_ok, relock, fw_take;
  assign ctrl_ok  = wr_ctrl && unlocked && !busy_q;
  assign relock   = ctrl_ok && reg_wdata[CB_LOCK];
  assign fw_ready = !busy_q && !wr_ctrl;
  assign fw_take  = fw_valid && fw_ready;

  flc_keylock u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_we   (wr_key),
    .key_val  (reg_wdata),
    .relock   (relock),
    .unlocked (unlocked)
  );

  logic [3:0] fw_sect;
  flc_sector_map #(.UNIT(UNIT), .AW(AW)) u_map (
    .addr (fw_addr),
    .sect (fw_sect)
  );

  logic [15:0] wp16;
  assign wp16 = {4'd0, wp_mask};

  // decode of a control write or data beat
  logic       start;
  op_e        start_op;
  logic [3:0] start_sect;
  logic [3:0] n_snb;
  logic [2:0] amask;

  always_comb begin
    err_set    = '0;
    start      = 1'b0;
    start_op   = OP_NONE;
    n_snb      = reg_wdata[CB_SNB_LO +: 4];
    start_sect = n_snb;
    amask      = 3'((4'd1 << fw_size) - 4'd1);
    if (wr_ctrl && !unlocked) err_set[E_SEQ] = 1'b1;
    if (ctrl_ok && reg_wdata[CB_STRT]) begin
      if (reg_wdata[CB_SER] && reg_wdata[CB_MER]) begin
        err_set[E_SEQ] = 1'b1;
      end else if (reg_wdata[CB_SER]) begin
        if (int'(n_snb) >= NUM_SECT) err_set[E_OPE] = 1'b1;
        else if (wp16[n_snb])        err_set[E_WRP] = 1'b1;
        else begin
          start    = 1'b1;
          start_op = OP_SECT;
        end
      end else if (reg_wdata[CB_MER]) begin
        if (|wp_mask) err_set[E_WRP] = 1'b1;
        else begin
          start    = 1'b1;
          start_op = OP_MASS;
        end
      end
    end
    if (fw_take) begin
      if (!unlocked || !pg_q)              err_set[E_SEQ] = 1'b1;
      else if (fw_size != psz_q)           err_set[E_PAR] = 1'b1;
      else if (|(fw_addr[2:0] & amask))    err_set[E_ALN] = 1'b1;
      else if (wp16[fw_sect])              err_set[E_WRP] = 1'b1;
      else begin
        start      = 1'b1;
        start_op   = OP_PROG;
        start_sect = fw_sect;
      end
    end
  end

  assign err_clr = wr_stat ? {reg_wdata[7], reg_wdata[6], reg_wdata[5],
                              reg_wdata[4], reg_wdata[1]} : 5'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= (err_q & ~err_clr) | err_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pg_q  <= 1'b0;
      ser_q <= 1'b0;
      mer_q <= 1'b0;
      snb_q <= '0;
      psz_q <= '0;
    end else if (ctrl_ok) begin
      pg_q  <= reg_wdata[CB_PG];
      ser_q <= reg_wdata[CB_SER];
      mer_q <= reg_wdata[CB_MER];
      snb_q <= reg_wdata[CB_SNB_LO +: 4];
      psz_q <= reg_wdata[CB_PSZ_LO +: 2];
    end
  end

  // operation sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      op_q     <= OP_NONE;
      sect_q   <= '0;
      paddr_q  <= '0;
      psz_op_q <= '0;
      pdata_q  <= '0;
    end else if (start) begin
      busy_q   <= 1'b1;
      cnt_q    <= (start_op == OP_PROG) ? CNT_W'(PROG_CYCLES - 1) : CNT_W'(ERASE_CYCLES - 1);
      op_q     <= start_op;
      sect_q   <= start_sect;
      paddr_q  <= fw_addr;
      psz_op_q <= fw_size;
      pdata_q  <= fw_data;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
        op_q   <= OP_NONE;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  logic fire;
  assign fire = busy_q && (cnt_q == '0);

  flc_array #(.UNIT(UNIT), .AW(AW)) u_arr (
    .clk        (clk),
    .rst_n      (rst_n),
    .erase_go   (fire && (op_q == OP_SECT || op_q == OP_MASS)),
    .erase_all  (op_q == OP_MASS),
    .erase_sect (sect_q),
    .prog_go    (fire && (op_q == OP_PROG)),
    .prog_addr  (paddr_q),
    .prog_size  (psz_op_q),
    .prog_data  (pdata_q),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data)
  );

  logic [31:0] status_word, ctrl_word;
  assign status_word = {15'd0, busy_q, 8'd0, err_q[E_SEQ], err_q[E_PAR],
                        err_q[E_ALN], err_q[E_WRP], 2'b00, err_q[E_OPE], 1'b0};
  assign ctrl_word   = {~unlocked, 21'd0, psz_q, 1'b0, snb_q, mer_q, ser_q, pg_q};

  always_comb begin
    unique case (reg_addr)
      OFF_STAT: reg_rdata = status_word;
      OFF_CTRL: reg_rdata = ctrl_word;
      default:  reg_rdata = 32'd0;
    endcase
  end

  assign busy = busy_q;

endmodule

// File: rtl/flc_cmd_if_chk.sv
module flc_cmd_if_chk #(
  parameter int AW           = 10,
  parameter int ERASE_CYCLES = 20,
  parameter int PROG_CYCLES  = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          unlocked,
  input logic          fw_valid,
  input logic          fw_ready,
  input logic          reg_valid,
  input logic          reg_write,
  input logic [AW-1:0] rd_addr,
  input logic [7:0]    rd_data,
  input logic [4:0]    err_q,
  input logic [31:0]   ctrl_word
);

  logic [15:0] run;
  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else        run <= busy ? run + 16'd1 : 16'd0;
  end

  logic took;
  assign took = (reg_valid && reg_write) || (fw_valid && fw_ready);

  assert_busy_needs_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(unlocked));

  assert_busy_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (int'(run) == ERASE_CYCLES || int'(run) == PROG_CYCLES));

  assert_array_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(rd_addr) && !$fell(busy)) |-> $stable(rd_data));

  assert_error_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(err_q & ~$past(err_q))) |-> $past(took));

  assert_ctrl_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ctrl_word));

endmodule

bind flc_cmd_if flc_cmd_if_chk #(
  .AW(AW), .ERASE_CYCLES(ERASE_CYCLES), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .unlocked  (unlocked),
  .fw_valid  (fw_valid),
  .fw_ready  (fw_ready),
  .reg_valid (reg_valid),
  .reg_write (reg_write),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .err_q     (err_q),
  .ctrl_word (ctrl_word)
);

// File: tb/flc_cmd_if_test.sv
module flc_cmd_if_test;

  localparam int ERASE_N = 20;
  localparam int PROG_N  = 4;
  localparam logic [4:0] A_KEY = 5'h04, A_STAT = 5'h0C, A_CTRL = 5'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0, reg_write = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        fw_valid = 1'b0, fw_ready;
  logic [9:0]  fw_addr = '0;
  logic [1:0]  fw_size = '0;
  logic [63:0] fw_data = '0;
  logic [11:0] wp_mask = '0;
  logic [9:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        busy;

  flc_cmd_if uut (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fw_valid(fw_valid), .fw_ready(fw_ready), .fw_addr(fw_addr),
    .fw_size(fw_size), .fw_data(fw_data), .wp_mask(wp_mask),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [7:0] sh [1024];

  typedef struct packed {
    logic [1:0]  psz;
    logic [1:0]  sz;
    logic [9:0]  addr;
    logic [63:0] data;
    logic [7:0]  err;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{2'd2, 2'd2, 10'h000, 64'h0000_0000_1234_5678, 8'h00},
    '{2'd0, 2'd0, 10'h013, 64'h0000_0000_0000_005A, 8'h00},
    '{2'd1, 2'd1, 10'h021, 64'h0000_0000_0000_0000, 8'h20},
    '{2'd3, 2'd2, 10'h040, 64'h0000_0000_0000_0000, 8'h40},
    '{2'd3, 2'd3, 10'h048, 64'h0102_0304_0506_0708, 8'h00},
    '{2'd2, 2'd2, 10'h000, 64'h0000_0000_FF00_0F0F, 8'h00},
    '{2'd0, 2'd1, 10'h101, 64'h0000_0000_0000_0000, 8'h40}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic fw_wr(input logic [9:0] a, input logic [1:0] s, input logic [63:0] d);
    @(negedge clk);
    fw_valid = 1'b1; fw_addr = a; fw_size = s; fw_data = d;
    #1;
    while (!fw_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    fw_valid = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    #1;
    while (busy) begin n++; @(negedge clk); #1; end
  endtask

  task automatic byte_chk(input string tag, input logic [9:0] a, input logic [7:0] exp);
    @(negedge clk);
    rd_addr = a;
    #1 chk(tag, 64'(rd_data), 64'(exp));
  endtask

  task automatic unlock();
    reg_wr(A_KEY, 32'h4567_0123);
    reg_wr(A_KEY, 32'hCDEF_89AB);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 1024; i++) sh[i] = 8'hFF;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int n;
    do_reset();

    // R1 reset state
    reg_rd(A_STAT, r); chk("R1 status", 64'(r), 64'h0);
    reg_rd(A_CTRL, r); chk("R1 ctrl", 64'(r), 64'h8000_0000);
    chk("R1 busy/ready", {62'd0, busy, fw_ready}, 64'h1);
    byte_chk("R1 byte0", 10'h000, 8'hFF);
    byte_chk("R1 byte_last", 10'h3FF, 8'hFF);

    // R3 locked control write, R12 clear
    reg_wr(A_CTRL, 32'h1);
    reg_rd(A_STAT, r); chk("R3 locked ctrl write", 64'(r), 64'h80);
    reg_rd(A_CTRL, r); chk("R3 ctrl unchanged", 64'(r), 64'h8000_0000);
    reg_wr(A_STAT, 32'h80);
    reg_rd(A_STAT, r); chk("R12 clear seq", 64'(r), 64'h0);

    // R2 unlock
    unlock();
    reg_rd(A_CTRL, r); chk("R2 unlocked", 64'(r), 64'h0);
    reg_wr(A_KEY, 32'h0);
    reg_rd(A_CTRL, r); chk("R2 extra key write", 64'(r), 64'h0);

    // R7/R8 vector table
    for (int v = 0; v < 7; v++) begin
      reg_wr(A_CTRL, 32'h1 | (32'(VECS[v].psz) << 8));
      fw_wr(VECS[v].addr, VECS[v].sz, VECS[v].data);
      wait_idle(n);
      chk($sformatf("R7 busy cycles vec%0d", v), 64'(n), (VECS[v].err == 8'h00) ? 64'(PROG_N) : 64'd0);
      reg_rd(A_STAT, r);
      chk($sformatf("R8 status vec%0d", v), 64'(r), 64'(VECS[v].err));
      if (VECS[v].err != 8'h00) reg_wr(A_STAT, 32'hF2);
      else
        for (int k = 0; k < (1 << VECS[v].sz); k++)
          sh[VECS[v].addr + 10'(k)] = sh[VECS[v].addr + 10'(k)] & VECS[v].data[8*k +: 8];
      for (int k = 0; k < 8; k++) begin
        logic [9:0] a;
        a = (VECS[v].addr & 10'h3F8) + 10'(k);
        byte_chk($sformatf("R7 array vec%0d byte%0d", v, k), a, sh[a]);
      end
    end

    // R5 sector erase of sector 1 (offsets 0x10..0x1F)
    reg_wr(A_CTRL, 32'h0001_000A);
    wait_idle(n); chk("R5 erase busy cycles", 64'(n), 64'(ERASE_N));
    byte_chk("R5 sector1 erased", 10'h013, 8'hFF);
    byte_chk("R5 sector0 kept", 10'h000, 8'h08);

    // R5 sector 4 spans 0x40..0x7F
    reg_wr(A_CTRL, 32'h1);
    fw_wr(10'h080, 2'd0, 64'h11); wait_idle(n);
    fw_wr(10'h07F, 2'd0, 64'h22); wait_idle(n);
    byte_chk("R5 pre-erase", 10'h07F, 8'h22);
    reg_wr(A_CTRL, 32'h0001_0022);
    wait_idle(n);
    byte_chk("R5 sector4 top", 10'h07F, 8'hFF);
    byte_chk("R5 sector4 inner", 10'h048, 8'hFF);
    byte_chk("R5 sector5 kept", 10'h080, 8'h11);

    // R9 write protect
    wp_mask = 12'h020;
    reg_wr(A_CTRL, 32'h1);
    fw_wr(10'h080, 2'd0, 64'h00); wait_idle(n);
    chk("R9 protected program busy", 64'(n), 64'd0);
    reg_rd(A_STAT, r); chk("R9 program wrperr", 64'(r), 64'h10);
    byte_chk("R9 byte kept", 10'h080, 8'h11);
    reg_wr(A_STAT, 32'h10);
    reg_wr(A_CTRL, 32'h0001_002A); wait_idle(n);
    reg_rd(A_STAT, r); chk("R9 erase wrperr", 64'(r), 64'h10);
    byte_chk("R9 erase no effect", 10'h080, 8'h11);
    reg_wr(A_STAT, 32'h10);
    reg_wr(A_CTRL, 32'h0001_0004); wait_idle(n);
    chk("R9 mass busy", 64'(n), 64'd0);
    reg_rd(A_STAT, r); chk("R9 mass wrperr", 64'(r), 64'h10);
    reg_wr(A_STAT, 32'h10);
    wp_mask = '0;

    // R10 operation and sequence faults, R6 both erase bits, R12 partial clear
    reg_wr(A_CTRL, 32'h0001_0062); wait_idle(n);
    chk("R10 bad sector busy", 64'(n), 64'd0);
    reg_rd(A_STAT, r); chk("R10 operr", 64'(r), 64'h02);
    reg_wr(A_CTRL, 32'h0);
    fw_wr(10'h080, 2'd0, 64'h00); wait_idle(n);
    reg_rd(A_STAT, r); chk("R10 pg clear seq", 64'(r), 64'h82);
    reg_wr(A_STAT, 32'h02);
    reg_rd(A_STAT, r); chk("R12 partial clear", 64'(r), 64'h80);
    reg_wr(A_STAT, 32'h00);
    reg_rd(A_STAT, r); chk("R12 zero write", 64'(r), 64'h80);
    reg_wr(A_STAT, 32'h80);
    reg_wr(A_CTRL, 32'h0001_0006); wait_idle(n);
    chk("R6 ser+mer busy", 64'(n), 64'd0);
    reg_rd(A_STAT, r); chk("R6 ser+mer seq", 64'(r), 64'h80);
    reg_wr(A_STAT, 32'h80);
    byte_chk("R6 ser+mer no effect", 10'h080, 8'h11);

    // R11 control ignored while busy
    reg_wr(A_CTRL, 32'h0001_0012);
    #1 chk("R11 ready low while busy", {63'd0, fw_ready}, 64'd0);
    reg_wr(A_CTRL, 32'h0000_0201);
    wait_idle(n);
    reg_rd(A_CTRL, r); chk("R11 ctrl unchanged", 64'(r), 64'h12);

    // R4 relock
    reg_wr(A_CTRL, 32'h8000_0000);
    reg_rd(A_CTRL, r); chk("R4 relocked", 64'(r), 64'h8000_0000);
    reg_wr(A_CTRL, 32'h1);
    reg_rd(A_STAT, r); chk("R4 locked write seq", 64'(r), 64'h80);
    reg_wr(A_STAT, 32'h80);
    unlock();
    reg_rd(A_CTRL, r); chk("R4 reunlock", 64'(r), 64'h0);

    // R6 mass erase
    reg_wr(A_CTRL, 32'h0001_0004);
    wait_idle(n); chk("R6 mass busy cycles", 64'(n), 64'(ERASE_N));
    byte_chk("R6 byte0", 10'h000, 8'hFF);
    byte_chk("R6 byte80", 10'h080, 8'hFF);

    // R3 wrong key step
    do_reset();
    reg_wr(A_KEY, 32'h4567_0123);
    reg_wr(A_KEY, 32'h0000_1234);
    unlock();
    reg_rd(A_CTRL, r); chk("R3 stays locked", 64'(r), 64'h8000_0000);
    reg_wr(A_CTRL, 32'h1);
    reg_rd(A_STAT, r); chk("R3 seq after bad key", 64'(r), 64'h80);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule